// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees I2C buses that a slave device holds stuck. The slave is usually left driving SDA low because the host was reset partway through a read. A single-cycle `start` pulse launches one run over every bus, in ascending index order. For each bus, the sequencer first samples SDA with both lines released. A bus whose SDA reads high is left alone.

For a bus whose SDA reads low, the sequencer runs a fixed wave on its open-drain SCL and SDA enables:

- a long settle with SCL released;
- a train of clock pulses, so the slave can shift out the rest of its byte;
- one extra clock that carries a not-acknowledge;
- a STOP condition.

It then samples SDA once more. If SDA is still low, it sets the bus's bit in a result mask.

Each line is modelled as a drive-low enable going out and a raw level coming back. The SDA level passes through a synchronizer before the sequencer uses it for any decision. A time unit is `TICK_DIV` system clocks. A single phase timer is loaded with each phase length in units and tells the state machine when the phase ends.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset, and at all times while `busy` is 0, every bit of `scl_drive_low` and `sda_drive_low` is 0 (released). After reset, `result_mask` is 0 and `done` is 0.
- R2: When a bus is probed and its synchronized SDA reads high, the bus is skipped after exactly one probe cycle and none of its lines is driven.
- R3: When a probed bus reads low, both of its lines stay released for `SETTLE_UNITS` units, which is the settle phase.
- R4: After the settle, `PULSES` clocks follow. Each clock is `HALF_UNITS` units with SCL released, then `HALF_UNITS` units with SCL driven low. SDA stays released throughout.
- R5: After the last clock, SDA is released while SCL stays low for `NAK_LEAD_UNITS` units. Then SCL is released for `HALF_UNITS` units and driven low for `HALF_UNITS` units.
- R6: The STOP takes three phases of `HALF_UNITS` units each: SDA and SCL both driven low; then SCL released with SDA still low; then both released. SDA is never newly driven low while SCL is released.
- R7: One cycle after the STOP, the synchronized SDA of the bus is sampled. If it is low, bit i+1 of `result_mask` is set, where bus i (0-based) maps to mask bit i+1. Bit 0 is always 0.
- R8: Buses are handled one at a time, in ascending index order. At most one bus has any line driven in a given cycle.
- R9: `result_mask` is cleared in the cycle after a `start` is accepted. At the end of a run, `done` is high for exactly one cycle, in the same cycle that `busy` first reads 0. While idle, `result_mask` holds its value.
- R10: A `start` that arrives while `busy` is 1 has no effect on the sequence, on its timing or on `result_mask`.
- R11: One time unit is exactly `TICK_DIV` clock cycles, so a phase of N units lasts N*`TICK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin a recovery run |
| sda_in | input | NUM_BUS | Raw SDA level of each bus |
| scl_drive_low | output | NUM_BUS | Per-bus enable that pulls SCL low; 0 releases the line |
| sda_drive_low | output | NUM_BUS | Per-bus enable that pulls SDA low; 0 releases the line |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| result_mask | output | NUM_BUS+1 | Bit i+1 is set if bus i is still stuck after recovery; bit 0 is unused |

## Verification
The assertions check four rules on every cycle:

- the lines stay released while idle;
- at most one bus is driven at a time;
- SDA is never newly pulled low while SCL is released;
- `done` is a lone pulse that ends `busy`, and the result mask can only gain bits during a run and stays frozen while idle.

Only the bench's scenarios can show the exact length and order of each phase, and that a slave which lets go after a few clocks is reported as recovered. The same holds for a slave that never lets go being flagged on the right mask bit, and for a start arriving mid-run leaving the wave untouched. The bench checks these by comparing every cycle against a phase list that it builds from the timing parameters.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROBE,
    ST_SETTLE,
    ST_PULSE_HI,
    ST_PULSE_LO,
    ST_NAK_LEAD,
    ST_NAK_HI,
    ST_NAK_LO,
    ST_STOP_LOW,
    ST_STOP_RISE,
    ST_STOP_REL,
    ST_VERIFY
  } phase_e;

  // {scl_low, sda_low} for the bus under service in a given phase
  function automatic logic [1:0] line_drive(input phase_e p);
    case (p)
      ST_PULSE_LO,
      ST_NAK_LEAD,
      ST_NAK_LO:    line_drive = 2'b10;
      ST_STOP_LOW:  line_drive = 2'b11;
      ST_STOP_RISE: line_drive = 2'b01;
      default:      line_drive = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/busclr_sync.sv
module busclr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '1;  // released lines read high
      else     chain_q <= {chain_q[STAGES-2:0], d[g]};
    end
    assign q[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/busclr_timer.sv
module busclr_timer #(
  parameter int TICK_DIV = 125,
  parameter int UNIT_W   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [UNIT_W-1:0] units,
  output logic              expire
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0]  div_q;
  logic [UNIT_W-1:0] unit_q;

  // The divider restarts on every load, so each unit is a full TICK_DIV cycles (R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      unit_q <= '0;
    end else if (load) begin
      div_q  <= DIV_MAX;
      unit_q <= units;
    end else if (unit_q != '0) begin
      if (div_q == '0) begin
        div_q  <= DIV_MAX;
        unit_q <= unit_q - 1'b1;
      end else begin
        div_q <= div_q - 1'b1;
      end
    end
  end

  assign expire = (unit_q == UNIT_W'(1)) && (div_q == '0);

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |-> (units != '0)); // R11

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import busclr_pkg::*;
#(
  parameter int NUM_BUS        = 3,
  parameter int TICK_DIV       = 125,
  parameter int SETTLE_UNITS   = 10000,
  parameter int HALF_UNITS     = 5,
  parameter int NAK_LEAD_UNITS = 1,
  parameter int PULSES         = 9,
  parameter int SYNC_STAGES    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NUM_BUS-1:0] sda_in,
  output logic [NUM_BUS-1:0] scl_drive_low,
  output logic [NUM_BUS-1:0] sda_drive_low,
  output logic               busy,
  output logic               done,
  output logic [NUM_BUS:0]   result_mask
);

  localparam int IDX_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;
  localparam int PCNT_W = $clog2(PULSES + 1);
  localparam int MAX_U  = (SETTLE_UNITS > HALF_UNITS)
                          ? ((SETTLE_UNITS > NAK_LEAD_UNITS) ? SETTLE_UNITS : NAK_LEAD_UNITS)
                          : ((HALF_UNITS > NAK_LEAD_UNITS) ? HALF_UNITS : NAK_LEAD_UNITS);
  localparam int UNIT_W = $clog2(MAX_U + 1);
  localparam int MASK_W = NUM_BUS + 1;
  localparam logic [UNIT_W-1:0] U_SETTLE = UNIT_W'(SETTLE_UNITS);
  localparam logic [UNIT_W-1:0] U_HALF   = UNIT_W'(HALF_UNITS);
  localparam logic [UNIT_W-1:0] U_LEAD   = UNIT_W'(NAK_LEAD_UNITS);
  localparam logic [IDX_W-1:0]  LAST_BUS = IDX_W'(NUM_BUS - 1);
  localparam logic [PCNT_W-1:0] LAST_PLS = PCNT_W'(PULSES - 1);

  logic [NUM_BUS-1:0] sda_sync;
  phase_e             state_q, state_d;
  logic [IDX_W-1:0]   bus_q, bus_d;
  logic [PCNT_W-1:0]  pulse_q, pulse_d;
  logic               load;
  logic [UNIT_W-1:0]  load_units;
  logic               expire;
  logic               finish;
  logic               fail_set;
  logic [NUM_BUS-1:0] scl_n, sda_n;

  busclr_sync #(.WIDTH(NUM_BUS), .STAGES(SYNC_STAGES)) u_sda_sync (
    .clk (clk),
    .rst (rst),
    .d   (sda_in),
    .q   (sda_sync)
  );

  busclr_timer #(.TICK_DIV(TICK_DIV), .UNIT_W(UNIT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .units  (load_units),
    .expire (expire)
  );

  // Next-phase logic
  always_comb begin
    state_d    = state_q;
    bus_d      = bus_q;
    pulse_d    = pulse_q;
    load       = 1'b0;
    load_units = U_HALF;
    finish     = 1'b0;
    fail_set   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin  // R10: accepted only here
          state_d = ST_PROBE;
          bus_d   = '0;
        end
      end
      ST_PROBE, ST_VERIFY: begin
        if (state_q == ST_PROBE && !sda_sync[bus_q]) begin  // R2
          state_d    = ST_SETTLE;
          load       = 1'b1;
          load_units = U_SETTLE;
        end else begin
          fail_set = (state_q == ST_VERIFY) && !sda_sync[bus_q];  // R7
          if (bus_q == LAST_BUS) begin  // R8
            state_d = ST_IDLE;
            finish  = 1'b1;
          end else begin
            state_d = ST_PROBE;
            bus_d   = bus_q + 1'b1;
          end
        end
      end
      ST_SETTLE: if (expire) begin
        state_d = ST_PULSE_HI;
        pulse_d = '0;
        load    = 1'b1;
      end
      ST_PULSE_HI: if (expire) begin
        state_d = ST_PULSE_LO;
        load    = 1'b1;
      end
      ST_PULSE_LO: if (expire) begin  // R4
        load = 1'b1;
        if (pulse_q == LAST_PLS) begin
          state_d    = ST_NAK_LEAD;
          load_units = U_LEAD;
        end else begin
          state_d = ST_PULSE_HI;
          pulse_d = pulse_q + 1'b1;
        end
      end
      ST_NAK_LEAD:  if (expire) begin state_d = ST_NAK_HI;    load = 1'b1; end
      ST_NAK_HI:    if (expire) begin state_d = ST_NAK_LO;    load = 1'b1; end
      ST_NAK_LO:    if (expire) begin state_d = ST_STOP_LOW;  load = 1'b1; end
      ST_STOP_LOW:  if (expire) begin state_d = ST_STOP_RISE; load = 1'b1; end
      ST_STOP_RISE: if (expire) begin state_d = ST_STOP_REL;  load = 1'b1; end
      ST_STOP_REL:  if (expire) state_d = ST_VERIFY;
      default:      state_d = ST_IDLE;
    endcase
  end

  // Line enables for the next phase, steered to the bus being served
  always_comb begin
    logic [1:0] drv;
    drv = line_drive(state_d);
    for (int b = 0; b < NUM_BUS; b++) begin
      scl_n[b] = drv[1] && (bus_d == IDX_W'(b));
      sda_n[b] = drv[0] && (bus_d == IDX_W'(b));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      bus_q         <= '0;
      pulse_q       <= '0;
      scl_drive_low <= '0;
      sda_drive_low <= '0;
      busy          <= 1'b0;
      done          <= 1'b0;
      result_mask   <= '0;
    end else begin
      state_q       <= state_d;
      bus_q         <= bus_d;
      pulse_q       <= pulse_d;
      scl_drive_low <= scl_n;
      sda_drive_low <= sda_n;
      busy          <= (state_d != ST_IDLE);
      done          <= finish;
      if (state_q == ST_IDLE && start)
        result_mask <= '0;  // R9
      else if (fail_set)
        result_mask <= result_mask | (MASK_W'(1) << (int'(bus_q) + 1));
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ((scl_drive_low | sda_drive_low) == '0)); // R1

  AST_ONE_BUS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(scl_drive_low | sda_drive_low)); // R8

  AST_NO_START_COND: assert property (@(posedge clk) disable iff (rst)
    ((sda_drive_low & ~$past(sda_drive_low) & ~scl_drive_low & ~$past(scl_drive_low)) == '0)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R9

  AST_MASK_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result_mask)); // R9

  AST_MASK_GROWS_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> ((result_mask & $past(result_mask)) == $past(result_mask))); // R10

endmodule

// File: tb/i2c_bus_clear_tb_top.sv
module i2c_bus_clear_tb_top;

  localparam int NB     = 3;
  localparam int TDIV   = 2;
  localparam int SETTLE = 20;
  localparam int HALF   = 5;
  localparam int LEAD   = 1;
  localparam int PULSES = 9;
  localparam int NEVER  = 1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NB-1:0] sda_in;
  logic [NB-1:0] scl_drive_low, sda_drive_low;
  logic          busy, done;
  logic [NB:0]   result_mask;

  always #4 clk = ~clk;  // 125 MHz

  i2c_bus_clear #(
    .NUM_BUS(NB), .TICK_DIV(TDIV), .SETTLE_UNITS(SETTLE), .HALF_UNITS(HALF),
    .NAK_LEAD_UNITS(LEAD), .PULSES(PULSES), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .busy(busy), .done(done), .result_mask(result_mask)
  );

  // Slave model: holds SDA low until it has seen need_v falling SCL edges
  int          need_v [NB];
  int          fall_cnt [NB];
  logic [NB-1:0] scl_prev;
  logic        clear_cnt = 1'b0;
  logic [NB-1:0] hold;

  initial begin
    for (int b = 0; b < NB; b++) need_v[b] = 0;
  end

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (clear_cnt) fall_cnt[b] = 0;
      else if (scl_drive_low[b] && !scl_prev[b]) fall_cnt[b] = fall_cnt[b] + 1;
    end
    scl_prev = scl_drive_low;
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      hold[b]   = (need_v[b] != 0) && (fall_cnt[b] < need_v[b]);
      sda_in[b] = !(sda_drive_low[b] || hold[b]);
    end
  end

  // Reference: list of expected per-cycle outputs
  typedef struct {
    bit          busy;
    bit          done;
    logic [NB-1:0] scl;
    logic [NB-1:0] sda;
    logic [NB:0]   mask;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [NB:0] cur_mask = '0;
  int          checks = 0;
  int          fails  = 0;
  bit          cmp_en = 1'b0;
  int          cyc    = 0;

  task automatic push(int n, bit b_busy, bit b_done, logic [NB-1:0] scl,
                      logic [NB-1:0] sda, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.busy = b_busy; e.done = b_done; e.scl = scl; e.sda = sda;
      e.mask = cur_mask; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic build_run();
    int u;
    u = TDIV;  // R11: one unit = TDIV cycles
    push(1, 0, 0, '0, '0, "R1");  // the cycle before the start edge
    cur_mask = '0;                // R9
    for (int b = 0; b < NB; b++) begin
      logic [NB-1:0] bit_b;
      bit_b = NB'(1) << b;
      push(1, 1, 0, '0, '0, "R2 R8");
      if (need_v[b] != 0) begin
        push(SETTLE * u, 1, 0, '0, '0, "R3 R11");
        for (int p = 0; p < PULSES; p++) begin
          push(HALF * u, 1, 0, '0, '0, "R4");
          push(HALF * u, 1, 0, bit_b, '0, "R4");
        end
        push(LEAD * u, 1, 0, bit_b, '0, "R5 R11");
        push(HALF * u, 1, 0, '0, '0, "R5");
        push(HALF * u, 1, 0, bit_b, '0, "R5");
        push(HALF * u, 1, 0, bit_b, bit_b, "R6");
        push(HALF * u, 1, 0, '0, bit_b, "R6");
        push(HALF * u, 1, 0, '0, '0, "R6");
        push(1, 1, 0, '0, '0, "R7");
        if (need_v[b] > PULSES + 1) cur_mask[b+1] = 1'b1;  // R7
      end
    end
    push(1, 0, 1, '0, '0, "R9");
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else begin
        e.busy = 0; e.done = 0; e.scl = '0; e.sda = '0; e.mask = cur_mask; e.tag = "R1 R9";
      end
      checks++;
      if (busy !== e.busy || done !== e.done || scl_drive_low !== e.scl ||
          sda_drive_low !== e.sda || result_mask !== e.mask) begin
        fails++;
        $display("FAIL %s: actual busy=%b done=%b scl=%b sda=%b mask=%b expected busy=%b done=%b scl=%b sda=%b mask=%b",
                 e.tag, busy, done, scl_drive_low, sda_drive_low, result_mask,
                 e.busy, e.done, e.scl, e.sda, e.mask);
      end
    end
  end

  task automatic run_case(int n0, int n1, int n2, bit poke);
    need_v[0] = n0; need_v[1] = n1; need_v[2] = n2;
    clear_cnt = 1'b1;
    repeat (4) @(posedge clk);
    #2 clear_cnt = 1'b0;
    @(posedge clk);
    #2;
    build_run();
    start = 1'b1;
    @(posedge clk);
    #2 start = 1'b0;
    if (poke) begin
      repeat (100) @(posedge clk);
      #2 start = 1'b1;  // R10: must be ignored
      @(posedge clk);
      #2 start = 1'b0;
    end
    wait (q.size() == 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic check_mask(logic [NB:0] exp, string tag);
    checks++;
    if (result_mask !== exp) begin
      fails++;
      $display("FAIL %s: actual mask=%b expected mask=%b", tag, result_mask, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual=no end of run expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    checks++;  // R1 reset state
    if (busy !== 0 || done !== 0 || scl_drive_low !== '0 || sda_drive_low !== '0 || result_mask !== '0) begin
      fails++;
      $display("FAIL R1: actual busy=%b done=%b scl=%b sda=%b mask=%b expected all zero",
               busy, done, scl_drive_low, sda_drive_low, result_mask);
    end
    #1 cmp_en = 1'b1;

    run_case(0, 0, 0, 0);               // R2: all buses idle-high, skipped
    check_mask('0, "R2");
    run_case(0, 3, 0, 0);               // bus 1 slave lets go after 3 clocks
    check_mask('0, "R4");
    run_case(NEVER, 0, 9, 1);           // R10 start mid-run; bus 0 stays stuck
    check_mask(4'b0010, "R7 R10");
    run_case(10, NEVER, NEVER, 0);      // release on the NAK clock; two stuck
    check_mask(4'b1100, "R7");
    run_case(0, 0, 0, 0);               // R9: mask cleared by the new run
    check_mask('0, "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule